// File: doc/BRIEF.md
# Burst Address Counter

This block is the address front end of one memory port. Every rising clock edge it picks the address that the access in the following cycle uses. It can take a fresh address from the port's address pins. It can step the stored address up by one for a burst. It can keep the stored address so that a read returns the same word again. It can also force the address to zero. Each port of a multi-port memory gets its own instance, clocked by that port's clock.

Three active-low strobes choose the action: clear, load and step. Clear wins over load, and load wins over step. When all three are high, the stored address is held. A clear costs no idle cycle: the access in the cycle that follows the clearing edge goes to address zero. The next edge can already step to address one. No chip-select or byte-lane input has any effect on this block. Stepping wraps from the top of the address space back to zero. An asynchronous active-high reset puts the stored address at zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_i` is high, `addr_o` is 0 at once, without waiting for a clock edge.
- R2: A rising edge with `clear_n_i` low makes `addr_o` 0 from that edge on. It adds no idle cycle, so a step at the next edge gives 1.
- R3: A rising edge with `clear_n_i` high and `load_n_i` low makes `addr_o` equal to the `ext_addr_i` value sampled at that edge.
- R4: A rising edge with `clear_n_i` and `load_n_i` high and `step_n_i` low makes `addr_o` one more than its value before the edge.
- R5: A rising edge with all three strobes high leaves `addr_o` unchanged, whatever `ext_addr_i` carries.
- R6: A step from the all-ones address (8191 for the default 13-bit width) gives 0, and the next step gives 1.
- R7: Clear has priority: with `clear_n_i` low, `addr_o` becomes 0 even when `load_n_i` and `step_n_i` are also low.
- R8: Load has priority over step: with `load_n_i` and `step_n_i` both low, `addr_o` becomes `ext_addr_i` and is not incremented.
- R9: `addr_o` changes only at a rising clock edge (or on reset). A strobe applied between edges leaves `addr_o` as it was until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock; all strobes are sampled on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset; sets the stored address to 0 |
| ext_addr_i | input | ADDR_W (13) | Address from the port pins, captured on a load |
| load_n_i | input | 1 | Active-low load strobe |
| step_n_i | input | 1 | Active-low increment strobe |
| clear_n_i | input | 1 | Active-low clear strobe |
| addr_o | output | ADDR_W (13) | Internal address used by the access in the current cycle |

## Verification
The assertions check the edge-to-edge update rule on every cycle: zero after a clear, the sampled pin value after a load, old value plus one (modulo the width) after a step, and an unchanged value after an idle edge. Those checks cover R2 through R8 for every input combination the bench happens to drive. The asynchronous effect of reset in the middle of a cycle (R1) can only be shown by the bench's scenarios. The same holds for the value staying put between edges while strobes change (R9), and for the concrete wrap sequence 8190, 8191, 0, 1 (R6).

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   // Action applied to the stored address at a rising edge
   typedef enum logic [1:0] {
      ACT_KEEP  = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_LOAD  = 2'd2,
      ACT_ZERO  = 2'd3
   } addr_act_e;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
   import burst_addr_pkg::*;
(
   input  logic      clear_n_i,
   input  logic      load_n_i,
   input  logic      step_n_i,
   output addr_act_e act_o
);

   // Fixed priority: clear, then load, then step, else keep
   always_comb begin
      if (!clear_n_i)      act_o = ACT_ZERO;
      else if (!load_n_i)  act_o = ACT_LOAD;
      else if (!step_n_i)  act_o = ACT_STEP;
      else                 act_o = ACT_KEEP;
   end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  addr_act_e         act_i,
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] ext_i,
   output logic [ADDR_W-1:0] nxt_o
);

   localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] ZERO = '0;

   logic [ADDR_W-1:0] inc;

   // Increment truncates to ADDR_W bits, so the all-ones value rolls to zero
   generate
      if (ADDR_W == 1) begin : g_inc_toggle
         assign inc = ~cur_i;
      end else begin : g_inc_add
         assign inc = cur_i + ONE;
      end
   endgenerate

   always_comb begin
      unique case (act_i)
         ACT_ZERO: nxt_o = ZERO;
         ACT_LOAD: nxt_o = ext_i;
         ACT_STEP: nxt_o = inc;
         default:  nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] ext_addr_i,
   input  logic              load_n_i,
   input  logic              step_n_i,
   input  logic              clear_n_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned MAX_ADDR_W = 32;

   generate
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W must lie in 1..%0d", MAX_ADDR_W);
      end
   endgenerate

   addr_act_e         act;
   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] addr_q;

   burst_addr_decode i_decode (
      .clear_n_i (clear_n_i),
      .load_n_i  (load_n_i),
      .step_n_i  (step_n_i),
      .act_o     (act)
   );

   burst_addr_next #(.ADDR_W(ADDR_W)) i_next (
      .act_i (act),
      .cur_i (addr_q),
      .ext_i (ext_addr_i),
      .nxt_o (nxt)
   );

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) addr_q <= '0;
      else       addr_q <= nxt;
   end

   assign addr_o = addr_q;

   // Edge-to-edge update rules, checked at the ports
   AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      !clear_n_i |=> addr_o == '0);                                      // R2
   AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
      (!clear_n_i && !load_n_i) |=> addr_o == '0);                       // R7
   AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
      (clear_n_i && !load_n_i) |=> addr_o == $past(ext_addr_i));         // R3
   AST_LOAD_OVER_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (clear_n_i && !load_n_i && !step_n_i) |=> addr_o == $past(ext_addr_i)); // R8
   AST_STEP_PLUS_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (clear_n_i && load_n_i && !step_n_i) |=>
         addr_o == ADDR_W'($past(addr_o) + 1'b1));                       // R4
   AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (clear_n_i && load_n_i && !step_n_i && (&addr_o)) |=> addr_o == '0); // R6
   AST_IDLE_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (clear_n_i && load_n_i && step_n_i) |=> $stable(addr_o));          // R5

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

   localparam int unsigned AW = 13;
   localparam int unsigned NVEC = 15;

   typedef struct packed {
      logic          clr_n;
      logic          ld_n;
      logic          st_n;
      logic [AW-1:0] ext;
      logic [AW-1:0] exp;
      logic [3:0]    req;
   } vec_t;

   // Walked from the reset value 0; expected value is addr_o after the edge
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b1, 1'b1, 13'd5,    13'd0,    4'd5},  // R5 idle keeps 0
      '{1'b1, 1'b0, 1'b1, 13'd100,  13'd100,  4'd3},  // R3 load
      '{1'b1, 1'b1, 1'b0, 13'd9,    13'd101,  4'd4},  // R4 step
      '{1'b1, 1'b1, 1'b0, 13'd9,    13'd102,  4'd4},  // R4 step
      '{1'b1, 1'b1, 1'b1, 13'd77,   13'd102,  4'd5},  // R5 pins ignored
      '{1'b1, 1'b0, 1'b0, 13'd200,  13'd200,  4'd8},  // R8 load beats step
      '{1'b0, 1'b0, 1'b0, 13'd300,  13'd0,    4'd7},  // R7 clear beats all
      '{1'b1, 1'b1, 1'b0, 13'd300,  13'd1,    4'd2},  // R2 no idle cycle
      '{1'b1, 1'b0, 1'b1, 13'd8190, 13'd8190, 4'd3},  // R3 load near top
      '{1'b1, 1'b1, 1'b0, 13'd0,    13'd8191, 4'd4},  // R4 step to top
      '{1'b1, 1'b1, 1'b0, 13'd0,    13'd0,    4'd6},  // R6 wrap
      '{1'b1, 1'b1, 1'b0, 13'd0,    13'd1,    4'd6},  // R6 after wrap
      '{1'b0, 1'b1, 1'b1, 13'd55,   13'd0,    4'd2},  // R2 plain clear
      '{1'b1, 1'b0, 1'b1, 13'd4660, 13'd4660, 4'd3},  // R3 load
      '{1'b0, 1'b1, 1'b0, 13'd1,    13'd0,    4'd7}   // R7 clear beats step
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] ext = '0;
   logic          ld_n = 1'b1, st_n = 1'b1, clr_n = 1'b1;
   logic [AW-1:0] addr;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
      .clk_i      (clk),
      .rst_i      (rst),
      .ext_addr_i (ext),
      .load_n_i   (ld_n),
      .step_n_i   (st_n),
      .clear_n_i  (clr_n),
      .addr_o     (addr)
   );

   task automatic check(input int req, input logic [AW-1:0] exp);
      n_chk++;
      if (addr !== exp) begin
         n_bad++;
         $display("FAIL R%0d: addr_o=%0d expected %0d", req, addr, exp);
      end
   endtask

   task automatic drive(input logic c, input logic l, input logic s,
                        input logic [AW-1:0] a);
      @(negedge clk);
      clr_n = c; ld_n = l; st_n = s; ext = a;
   endtask

   initial begin
      #1;
      check(1, '0);                 // R1 value under reset
      repeat (3) @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i].clr_n, VEC[i].ld_n, VEC[i].st_n, VEC[i].ext);
         @(posedge clk); #1;
         check(int'(VEC[i].req), VEC[i].exp);
      end

      // R9: strobe applied between edges has no effect before the edge
      drive(1'b1, 1'b0, 1'b1, 13'd321);
      #1;
      check(9, 13'd0);              // R9 still old value
      @(posedge clk); #1;
      check(9, 13'd321);            // R9 updated at the edge

      // R1: asynchronous reset in mid-cycle clears at once
      drive(1'b1, 1'b1, 1'b1, 13'd0);
      #2 rst = 1'b1;
      #1;
      check(1, 13'd0);              // R1 no edge needed
      @(negedge clk);
      rst = 1'b0;

      // R4/R6 long burst from a load, wraps once
      drive(1'b1, 1'b0, 1'b1, 13'd8189);
      for (int k = 0; k < 5; k++) begin
         drive(1'b1, 1'b1, 1'b0, 13'd0);
         @(posedge clk); #1;
         check(6, AW'(13'd8190 + k)); // R6 8190, 8191, 0, 1, 2
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule